// File: doc/BRIEF.md
# Dual-Clock Fall-Through FIFO with Ready Flags

This block carries data words from a write clock domain to an unrelated read clock domain. Words are written into a RAM through the write port. The read side keeps one output register in front of the RAM. Whenever that register is empty and the RAM holds a word, the read side moves the word into the register without waiting for a read request. The oldest stored word is therefore always present on the data output. A read request only consumes it, and the next word then takes its place. Because of the output register, the block stores one word more than the RAM depth.

Each side has an active-low ready flag. The write side flag is LOW while there is room and HIGH when the FIFO holds its full capacity. The read side flag is LOW while a valid word sits on the data output and HIGH when nothing is there. The write and read pointers cross between the clock domains as Gray code, each through a two-flop synchroniser. The read flag settles through three read-clock register stages and the write flag through a synchroniser pair plus its own register. An active-low master reset clears both domains asynchronously.

Top module: `fwft_fifo`

## Requirements
- R1: While and after master reset, with no writes, in_ready_no is 0 (room available), out_ready_no is 1 (no data) and rd_data_o is 0.
- R2: A word written into an empty FIFO appears on rd_data_o and out_ready_no falls to 0 without any read request. This happens on the third rising rclk_i edge after the wclk_i edge that accepted the write, and out_ready_no is still 1 after the second such edge.
- R3: Words leave in the order they were written. A read is taken on a rising rclk_i edge where rd_en_i is 1 and out_ready_no is 0, and rd_data_o holds its word for as long as no read is taken.
- R4: Capacity is D = 2**AW + 1 words. After reset, with no reads and with spaced writes, in_ready_no is 0 before the D-th write and 1 right after the wclk_i edge of the D-th write.
- R5: A write attempted while in_ready_no is 1 is discarded. It does not change the stored contents and never appears on the read side.
- R6: When the FIFO is full, the first read returns in_ready_no to 0 on the third rising wclk_i edge after the read edge, and in_ready_no is still 1 after the second such edge.
- R7: On the rclk_i edge that reads the last stored word, out_ready_no rises to 1, which blocks further reads.
- R8: rd_en_i has no effect while out_ready_no is 1. rd_data_o and out_ready_no stay unchanged, and the next word written is the next word read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk_i | input | 1 | Write clock |
| rclk_i | input | 1 | Read clock |
| rst_ni | input | 1 | Active-low asynchronous master reset, both domains |
| wr_en_i | input | 1 | Write request, sampled on rising wclk_i |
| wr_data_i | input | DW | Write data |
| in_ready_no | output | 1 | Active-low input ready: 1 when full |
| rd_en_i | input | 1 | Read request, sampled on rising rclk_i |
| rd_data_o | output | DW | Oldest stored word (fall-through) |
| out_ready_no | output | 1 | Active-low output ready: 1 when no word is presented |

## Verification
Write acceptance is settled on the same wclk_i edge, and the write flag rises with the edge that fills the last slot. A read takes effect on its rclk_i edge: the next word or a raised read flag is visible right after that edge. Crossings take exactly three edges of the receiving clock: the read flag falls on the third rclk_i edge after a write edge, and the write flag falls on the third wclk_i edge after a read edge. The bench counts edges of each clock, notes the count at the edge that caused the event, and samples 1 ns after the second edge (old value expected) and after the third edge (new value expected). The two clock periods never share an edge, so these samples never fall on an edge.

// File: rtl/fwft_fifo_pkg.sv
package fwft_fifo_pkg;
  localparam int unsigned CONV_W = 32;

  function automatic logic [CONV_W-1:0] bin_to_gray(input logic [CONV_W-1:0] b);
    return b ^ (b >> 1);
  endfunction

  function automatic logic [CONV_W-1:0] gray_to_bin(input logic [CONV_W-1:0] g);
    logic [CONV_W-1:0] b;
    b[CONV_W-1] = g[CONV_W-1];
    for (int i = CONV_W - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction
endpackage

// File: rtl/fwft_sync.sv
module fwft_sync #(
  parameter int unsigned W      = 10,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stg_q[0] <= '0;
    else         stg_q[0] <= d_i;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stg_q[s] <= '0;
      else         stg_q[s] <= stg_q[s-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/fwft_mem.sv
module fwft_mem #(
  parameter int unsigned DW = 18,
  parameter int unsigned AW = 9,
  localparam int unsigned WORDS = 1 << AW
) (
  input  logic          wclk_i,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [DW-1:0] rdata_o
);
  logic [DW-1:0] mem_q [WORDS];

  always_ff @(posedge wclk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  // combinational read: the output register is the only read stage
  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/fwft_wr_ctrl.sv
module fwft_wr_ctrl
  import fwft_fifo_pkg::*;
#(
  parameter int unsigned AW = 9,
  localparam int unsigned PW = AW + 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic [PW-1:0] rgray_s_i,
  output logic          we_o,
  output logic [AW-1:0] waddr_o,
  output logic [PW-1:0] wbin_o,
  output logic [PW-1:0] wgray_o,
  output logic          full_o
);
  localparam logic [PW-1:0] RAM_WORDS = PW'(1) << AW;

  logic [PW-1:0] wbin_q, wbin_d, wgray_q, rbin_s;
  logic          full_q, full_d;

  assign we_o   = wr_en_i & ~full_q;
  assign wbin_d = wbin_q + PW'(we_o);
  assign rbin_s = PW'(gray_to_bin(CONV_W'(rgray_s_i)));
  // RAM occupancy against the synchronised read pointer; stale pointer only delays release
  assign full_d = (wbin_d - rbin_s) == RAM_WORDS;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wbin_q  <= '0;
      wgray_q <= '0;
      full_q  <= 1'b0;
    end else begin
      wbin_q  <= wbin_d;
      wgray_q <= PW'(bin_to_gray(CONV_W'(wbin_d)));
      full_q  <= full_d;
    end
  end

  assign waddr_o = wbin_q[AW-1:0];
  assign wbin_o  = wbin_q;
  assign wgray_o = wgray_q;
  assign full_o  = full_q;
endmodule

// File: rtl/fwft_rd_ctrl.sv
module fwft_rd_ctrl
  import fwft_fifo_pkg::*;
#(
  parameter int unsigned DW = 18,
  parameter int unsigned AW = 9,
  localparam int unsigned PW = AW + 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          rd_en_i,
  input  logic [PW-1:0] wgray_s_i,
  input  logic [DW-1:0] mem_rdata_i,
  output logic [AW-1:0] raddr_o,
  output logic [PW-1:0] rgray_o,
  output logic [DW-1:0] rd_data_o,
  output logic          valid_o
);
  logic [PW-1:0] rbin_q, rbin_d, rgray_q, wbin_s;
  logic [DW-1:0] data_q;
  logic          valid_q, fire, ram_avail, load;

  assign wbin_s    = PW'(gray_to_bin(CONV_W'(wgray_s_i)));
  assign fire      = rd_en_i & valid_q;
  assign ram_avail = wbin_s != rbin_q;
  assign load      = ram_avail & (~valid_q | fire);
  assign rbin_d    = rbin_q + PW'(load);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rbin_q  <= '0;
      rgray_q <= '0;
      data_q  <= '0;
      valid_q <= 1'b0;
    end else begin
      rbin_q  <= rbin_d;
      rgray_q <= PW'(bin_to_gray(CONV_W'(rbin_d)));
      if (load) begin
        data_q  <= mem_rdata_i;
        valid_q <= 1'b1;
      end else if (fire) begin
        valid_q <= 1'b0;
      end
    end
  end

  assign raddr_o   = rbin_q[AW-1:0];
  assign rgray_o   = rgray_q;
  assign rd_data_o = data_q;
  assign valid_o   = valid_q;
endmodule

// File: rtl/fwft_fifo.sv
module fwft_fifo #(
  parameter int unsigned DW       = 18,
  parameter int unsigned AW       = 9,
  parameter int unsigned SYNC_STG = 2
) (
  input  logic          wclk_i,
  input  logic          rclk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic [DW-1:0] wr_data_i,
  output logic          in_ready_no,
  input  logic          rd_en_i,
  output logic [DW-1:0] rd_data_o,
  output logic          out_ready_no
);
  localparam int unsigned PW = AW + 1;

  logic          we, full, valid;
  logic [AW-1:0] waddr, raddr;
  logic [PW-1:0] w_bin, w_gray, r_gray, r_gray_ws, w_gray_rs;
  logic [DW-1:0] mem_rdata;

  fwft_wr_ctrl #(.AW(AW)) u_wr (
    .clk_i     (wclk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i),
    .rgray_s_i (r_gray_ws),
    .we_o      (we),
    .waddr_o   (waddr),
    .wbin_o    (w_bin),
    .wgray_o   (w_gray),
    .full_o    (full)
  );

  fwft_sync #(.W(PW), .STAGES(SYNC_STG)) u_sync_r2w (
    .clk_i  (wclk_i),
    .rst_ni (rst_ni),
    .d_i    (r_gray),
    .q_o    (r_gray_ws)
  );

  fwft_sync #(.W(PW), .STAGES(SYNC_STG)) u_sync_w2r (
    .clk_i  (rclk_i),
    .rst_ni (rst_ni),
    .d_i    (w_gray),
    .q_o    (w_gray_rs)
  );

  fwft_mem #(.DW(DW), .AW(AW)) u_mem (
    .wclk_i  (wclk_i),
    .we_i    (we),
    .waddr_i (waddr),
    .wdata_i (wr_data_i),
    .raddr_i (raddr),
    .rdata_o (mem_rdata)
  );

  fwft_rd_ctrl #(.DW(DW), .AW(AW)) u_rd (
    .clk_i       (rclk_i),
    .rst_ni      (rst_ni),
    .rd_en_i     (rd_en_i),
    .wgray_s_i   (w_gray_rs),
    .mem_rdata_i (mem_rdata),
    .raddr_o     (raddr),
    .rgray_o     (r_gray),
    .rd_data_o   (rd_data_o),
    .valid_o     (valid)
  );

  assign in_ready_no  = full;
  assign out_ready_no = ~valid;
endmodule

// File: rtl/fwft_fifo_chk.sv
module fwft_fifo_chk
  import fwft_fifo_pkg::*;
#(
  parameter int unsigned DW = 18,
  parameter int unsigned AW = 9,
  localparam int unsigned PW = AW + 1
) (
  input logic          wclk_i,
  input logic          rclk_i,
  input logic          rst_ni,
  input logic          wr_en_i,
  input logic          rd_en_i,
  input logic          in_ready_no,
  input logic          out_ready_no,
  input logic [DW-1:0] rd_data_o,
  input logic [PW-1:0] w_ptr,
  input logic [PW-1:0] w_gray,
  input logic [PW-1:0] r_gray_sync
);
  localparam logic [PW-1:0] RAM_WORDS = PW'(1) << AW;

  logic [PW-1:0] r_ptr_sync;
  assign r_ptr_sync = PW'(gray_to_bin(CONV_W'(r_gray_sync)));

  p_no_overflow_r4: assert property (@(posedge wclk_i) disable iff (!rst_ni)
    (w_ptr - r_ptr_sync) <= RAM_WORDS);

  p_full_drops_write_r5: assert property (@(posedge wclk_i) disable iff (!rst_ni)
    (in_ready_no && wr_en_i) |=> $stable(w_ptr));

  // order across the crossing relies on single-bit pointer steps
  p_gray_step_r3: assert property (@(posedge wclk_i) disable iff (!rst_ni)
    $onehot0(w_gray ^ $past(w_gray)));

  p_word_held_r3: assert property (@(posedge rclk_i) disable iff (!rst_ni)
    (!out_ready_no && !rd_en_i) |=> (!out_ready_no && $stable(rd_data_o)));

  p_empty_quiet_r8: assert property (@(posedge rclk_i) disable iff (!rst_ni)
    (out_ready_no && $past(out_ready_no)) |-> $stable(rd_data_o));
endmodule

bind fwft_fifo fwft_fifo_chk #(.DW(DW), .AW(AW)) u_chk (
  .wclk_i       (wclk_i),
  .rclk_i       (rclk_i),
  .rst_ni       (rst_ni),
  .wr_en_i      (wr_en_i),
  .rd_en_i      (rd_en_i),
  .in_ready_no  (in_ready_no),
  .out_ready_no (out_ready_no),
  .rd_data_o    (rd_data_o),
  .w_ptr        (w_bin),
  .w_gray       (w_gray),
  .r_gray_sync  (r_gray_ws)
);

// File: tb/fwft_fifo_bench.sv
`timescale 1ns/1ps
module fwft_fifo_bench;
  localparam int DW = 18;
  localparam int AW = 9;
  localparam int D  = (1 << AW) + 1;

  logic wclk_i = 1'b0, rclk_i = 1'b0, rst_ni = 1'b0;
  logic wr_en_i = 1'b0, rd_en_i = 1'b0;
  logic [DW-1:0] wr_data_i = '0;
  logic in_ready_no, out_ready_no;
  logic [DW-1:0] rd_data_o;

  fwft_fifo #(.DW(DW), .AW(AW)) u_fwft_fifo (.*);

  always #4 wclk_i = ~wclk_i;
  initial begin #1.3; forever #5.5 rclk_i = ~rclk_i; end

  int checks = 0, errors = 0, popped = 0;
  int wcnt = 0, rcnt = 0, last_w_rcnt = 0, last_r_wcnt = 0;
  logic [DW-1:0] exp_q[$];
  event rd_evt;

  always @(posedge wclk_i) wcnt++;
  always @(posedge rclk_i) rcnt++;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic wr_try(input logic [DW-1:0] d, output bit acc);
    @(negedge wclk_i);
    acc = !in_ready_no;
    if (acc) exp_q.push_back(d);
    wr_en_i = 1'b1; wr_data_i = d;
    @(posedge wclk_i);
    last_w_rcnt = rcnt;
    #1 wr_en_i = 1'b0;
  endtask

  task automatic rd_one();
    do begin @(negedge rclk_i); #1; end while (out_ready_no);
    rd_en_i = 1'b1; -> rd_evt;
    @(posedge rclk_i);
    last_r_wcnt = wcnt;
    #1 rd_en_i = 1'b0;
  endtask

  // monitor: compares each consumed word with the scoreboard queue
  initial forever begin
    @(rd_evt);
    if (exp_q.size() == 0) chk(0, "R3 unexpected word", rd_data_o, 0);
    else begin
      logic [DW-1:0] e;
      e = exp_q.pop_front();
      chk(rd_data_o == e, "R3 order", rd_data_o, e);
    end
    popped++;
  end

  initial begin
    #1_500_000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    bit acc;
    int n0;
    logic [DW-1:0] d0;
    #20;
    chk(in_ready_no == 1'b0, "R1 in_ready_no in reset", in_ready_no, 0);
    chk(out_ready_no == 1'b1, "R1 out_ready_no in reset", out_ready_no, 1);
    #30.1 rst_ni = 1'b1;
    repeat (5) @(posedge rclk_i);
    #1;
    chk(out_ready_no == 1'b1, "R1 out_ready_no after reset", out_ready_no, 1);
    chk(rd_data_o == '0, "R1 rd_data_o after reset", rd_data_o, 0);
    chk(in_ready_no == 1'b0, "R1 in_ready_no after reset", in_ready_no, 0);

    // R2: fall-through latency
    wr_try(18'h1234, acc);
    n0 = last_w_rcnt;
    wait (rcnt == n0 + 2); #1;
    chk(out_ready_no == 1'b1, "R2 flag before third edge", out_ready_no, 1);
    wait (rcnt == n0 + 3); #1;
    chk(out_ready_no == 1'b0, "R2 flag at third edge", out_ready_no, 0);
    chk(rd_data_o == 18'h1234, "R2 word without read", rd_data_o, 18'h1234);
    rd_one();
    chk(out_ready_no == 1'b1, "R7 flag after last read", out_ready_no, 1);

    // R8: reads while empty
    d0 = rd_data_o;
    @(negedge rclk_i); #1 rd_en_i = 1'b1;
    repeat (6) @(posedge rclk_i);
    #1 rd_en_i = 1'b0;
    chk(out_ready_no == 1'b1, "R8 flag while empty", out_ready_no, 1);
    chk(rd_data_o == d0, "R8 data while empty", rd_data_o, d0);
    wr_try(18'h2A5, acc);
    repeat (6) @(posedge rclk_i);
    #1;
    chk(rd_data_o == 18'h2A5, "R8 next word after empty reads", rd_data_o, 18'h2A5);
    rd_one();

    // R3: concurrent streaming with irregular gaps on both sides
    popped = 0;
    fork
      begin
        for (int i = 0; i < 60; i++) begin
          do wr_try(DW'(18'h3000 + i * 7), acc); while (!acc);
          repeat ($urandom % 3) @(posedge wclk_i);
        end
      end
      begin
        forever begin
          @(negedge rclk_i); #1;
          if (popped >= 60) begin rd_en_i = 1'b0; break; end
          if (!out_ready_no && ($urandom % 4 != 0)) begin rd_en_i = 1'b1; -> rd_evt; end
          else rd_en_i = 1'b0;
        end
      end
    join
    repeat (8) @(posedge rclk_i);
    #1;
    chk(out_ready_no == 1'b1 && exp_q.size() == 0, "R3 stream drained", exp_q.size(), 0);

    // R4: capacity D
    for (int i = 0; i < D; i++) begin
      if (i == D - 1) begin
        #1;
        chk(in_ready_no == 1'b0, "R4 room before last write", in_ready_no, 0);
      end
      wr_try(DW'(18'h100 + i), acc);
      if (i == 0) repeat (10) @(posedge wclk_i);
    end
    #1;
    chk(in_ready_no == 1'b1, "R4 full after D writes", in_ready_no, 1);

    // R5: write while full
    wr_try(18'h3FFFF, acc);
    chk(acc == 1'b0, "R5 write offered while full", acc, 0);
    repeat (4) @(posedge wclk_i);
    #1;
    chk(in_ready_no == 1'b1, "R5 still full", in_ready_no, 1);

    // R6: first read from full releases the write flag
    rd_one();
    n0 = last_r_wcnt;
    wait (wcnt == n0 + 2); #1;
    chk(in_ready_no == 1'b1, "R6 flag before third edge", in_ready_no, 1);
    wait (wcnt == n0 + 3); #1;
    chk(in_ready_no == 1'b0, "R6 flag at third edge", in_ready_no, 0);

    // drain; R7 on the last word, R5 dropped word never appears
    for (int i = 1; i < D; i++) rd_one();
    chk(out_ready_no == 1'b1, "R7 flag on last read edge", out_ready_no, 1);
    repeat (10) @(posedge rclk_i);
    #1;
    chk(out_ready_no == 1'b1, "R5 dropped word absent", out_ready_no, 1);
    chk(exp_q.size() == 0, "R5 scoreboard empty", exp_q.size(), 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule